// File: doc/BRIEF.md
# DRAM ECC Error Capture Unit

This unit sits next to the SECDED checker of a DDR memory controller. Each cycle the checker may raise a one-cycle error strobe with the error's attributes:
- kind (correctable single-bit or uncorrectable double-bit),
- chip select, bank, row and column,
- the 64-bit data word,
- the received and recomputed check bytes.

The unit keeps a separate count of each kind of error. It latches the full details of the most recent qualifying event, sets sticky cause flags and drives a maskable interrupt. A plain 32-bit register port gives software read and write access.

Single-bit events go through a programmable pacing threshold before they are captured. Double-bit events are always captured. The counters see every event whatever the threshold is. A control bit decides whether double-bit events are forwarded upstream as a one-cycle pulse.

Top module: `dram_ecc_capture`

## Requirements
- R1: After reset every register reads zero, and `irq` and `ue_fwd` are low.
- R2: A double-bit event (strobe with `err_dbe`=1) is always captured:
  - word 5 holds bank in bits 25:23, column in 22:8, chip select in 2:1 and the kind in bit 0 (1 = double-bit, 0 = single-bit);
  - word 4 holds the row in bits 23:8 and the computed check byte in 7:0;
  - word 3 holds the received check byte in 7:0;
  - words 1 and 2 hold the high and low data halves.
- R3: The single-bit threshold sits in word 0 bits 23:16.
  - At zero, no single-bit event is captured or flagged.
  - At N>0, the Nth single-bit event since the last single-bit capture or the last write of word 0 is captured.
  - So N=1 captures every one.
- R4: Word 6 counts every single-bit event and word 7 counts every double-bit event, whatever the threshold is. Both saturate at all-ones.
- R5: Writing zero to a counter clears it, and writing a nonzero value has no effect. A clear in the same cycle as an event of that kind leaves the count at 1.
- R6: Cause words 8 and 9 each set bit 1 on a captured double-bit event and bit 0 on a captured single-bit event. A written 0 clears a bit and a written 1 keeps it. An event that sets a bit wins over a clear of that bit in the same cycle.
- R7: Word 11 reads the captured received check byte XOR the captured computed check byte.
- R8: `irq` goes high one cycle after any bit of (word 8 OR word 9) AND the mask in word 10 bits 1:0 is set. It goes low one cycle after no such bit remains.
- R9: With word 0 bit 9 set, `ue_fwd` pulses high for one cycle, one cycle after a double-bit strobe. With that bit clear, or for single-bit strobes, it stays low.
- R10: Each capture overwrites all captured fields, so they always describe the latest captured event.
- R11: Reads of word addresses 12 to 15 return zero. Read data is registered: it appears one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_valid | input | 1 | One-cycle error strobe from the ECC checker |
| err_dbe | input | 1 | Error kind: 1 double-bit, 0 single-bit |
| err_cs | input | 2 | Chip select of the failing access |
| err_bank | input | 3 | Bank of the failing access |
| err_row | input | 16 | Row of the failing access |
| err_col | input | 15 | Column of the failing access |
| err_data | input | 64 | Failing data word |
| err_rx_ecc | input | 8 | Check byte read from memory |
| err_calc_ecc | input | 8 | Check byte recomputed from the data |
| reg_wen | input | 1 | Register write enable |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Masked OR of the cause flags |
| ue_fwd | output | 1 | Forwarded uncorrectable-error pulse |

## Verification
Saturation is the hardest state to reach from the ports: with 32-bit counters it would take billions of strobes. The bench therefore builds the unit with 4-bit counters and drives past fifteen double-bit events, reading the count after each one.

The threshold pacing is the second hard case. The bench sweeps thresholds 0 to 4 over eight single-bit events each, giving every event unique attributes. It predicts arithmetically which event must be the one left in the capture registers.

The same-cycle collisions, a counter clear or a cause clear landing on an event, are driven in one cycle from a single task.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int WORD_W = 32;
  localparam int ECC_W  = 8;
  localparam int ROW_W  = 16;
  localparam int COL_W  = 15;
  localparam int BANK_W = 3;
  localparam int CS_W   = 2;
  localparam int REG_AW = 4;

  // software-visible field positions
  localparam int THR_LSB  = 16;
  localparam int PROP_BIT = 9;
  localparam int ROW_LSB  = 8;
  localparam int COL_LSB  = 8;
  localparam int BANK_LSB = 23;
  localparam int CS_LSB   = 1;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL   = 4'd0,
    RA_DHI    = 4'd1,
    RA_DLO    = 4'd2,
    RA_RXECC  = 4'd3,
    RA_CALC   = 4'd4,
    RA_ADDR   = 4'd5,
    RA_SBECNT = 4'd6,
    RA_DBECNT = 4'd7,
    RA_CAUSE0 = 4'd8,
    RA_CAUSE1 = 4'd9,
    RA_MASK   = 4'd10,
    RA_SYND   = 4'd11
  } reg_addr_e;

  typedef struct packed {
    logic                  dbe;
    logic [CS_W-1:0]       cs;
    logic [BANK_W-1:0]     bank;
    logic [ROW_W-1:0]      row;
    logic [COL_W-1:0]      col;
    logic [2*WORD_W-1:0]   data;
    logic [ECC_W-1:0]      rx;
    logic [ECC_W-1:0]      calc;
  } err_rec_t;
endpackage

// File: rtl/ecc_evt_qual.sv
module ecc_evt_qual #(
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             err_valid,
  input  logic             err_dbe,
  input  logic [THR_W-1:0] thr,
  input  logic             thr_wr,
  output logic             sbe_evt,
  output logic             dbe_evt,
  output logic             sbe_cap,
  output logic             capture
);
  logic [THR_W-1:0] pace_q;
  logic [THR_W:0]   pace_inc;
  logic             thr_on;
  logic             pace_hit;

  assign sbe_evt  = err_valid & ~err_dbe;
  assign dbe_evt  = err_valid & err_dbe;
  assign thr_on   = (thr != '0);
  assign pace_inc = {1'b0, pace_q} + 1'b1;
  assign pace_hit = thr_on && (pace_inc >= {1'b0, thr});
  assign sbe_cap  = sbe_evt & pace_hit;
  assign capture  = dbe_evt | sbe_cap;

  always_ff @(posedge clk) begin
    if (rst || thr_wr) begin
      pace_q <= '0;
    end else if (sbe_evt && thr_on) begin
      pace_q <= pace_hit ? '0 : pace_inc[THR_W-1:0];
    end
  end

  // R3: pacing count stays below a nonzero threshold
  a_r3_pace_below_thr: assert property (@(posedge clk) disable iff (rst)
    (thr != '0) |-> (pace_q < thr));
  // R3: threshold of one captures every single-bit event
  a_r3_thr_one_all: assert property (@(posedge clk) disable iff (rst)
    (sbe_evt && thr == THR_W'(1)) |-> sbe_cap);
endmodule

// File: rtl/ecc_sat_counter.sv
module ecc_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  logic [W-1:0] base;

  always_comb begin
    base = clr ? '0 : cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (inc && base != '1) begin
      cnt <= base + 1'b1;
    end else begin
      cnt <= base;
    end
  end

  // R4: a full counter holds at all-ones
  a_r4_saturate: assert property (@(posedge clk) disable iff (rst)
    (cnt == '1 && !clr) |=> (cnt == '1));
  // R4: an event below saturation advances by exactly one
  a_r4_step_one: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && cnt != '1) |=> (cnt == $past(cnt) + 1'b1));
  // R5: clear without event empties the counter
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && !inc) |=> (cnt == '0));
endmodule

// File: rtl/ecc_cause_reg.sv
module ecc_cause_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] set,
  input  logic       wen,
  input  logic [1:0] wdata,
  output logic [1:0] q
);
  logic [1:0] kept;

  always_comb begin
    kept = wen ? (q & wdata) : q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      q <= kept | set;
    end
  end

  // R6: a set bit survives anything but a written zero
  a_r6_sticky_lo: assert property (@(posedge clk) disable iff (rst)
    (q[0] && !(wen && !wdata[0])) |=> q[0]);
  a_r6_sticky_hi: assert property (@(posedge clk) disable iff (rst)
    (q[1] && !(wen && !wdata[1])) |=> q[1]);
  // R6: a setting event wins over a same-cycle clear
  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
    set[1] |=> q[1]);
endmodule

// File: rtl/dram_ecc_capture.sv
module dram_ecc_capture
  import ecc_cap_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int THR_W     = 8,
  parameter int NUM_CAUSE = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  err_valid,
  input  logic                  err_dbe,
  input  logic [CS_W-1:0]       err_cs,
  input  logic [BANK_W-1:0]     err_bank,
  input  logic [ROW_W-1:0]      err_row,
  input  logic [COL_W-1:0]      err_col,
  input  logic [2*WORD_W-1:0]   err_data,
  input  logic [ECC_W-1:0]      err_rx_ecc,
  input  logic [ECC_W-1:0]      err_calc_ecc,
  input  logic                  reg_wen,
  input  logic [REG_AW-1:0]     reg_addr,
  input  logic [WORD_W-1:0]     reg_wdata,
  output logic [WORD_W-1:0]     reg_rdata,
  output logic                  irq,
  output logic                  ue_fwd
);
  localparam int DATA_W = 2 * WORD_W;

  logic [THR_W-1:0] thr_q;
  logic             prop_q;
  logic [1:0]       mask_q;
  err_rec_t         cap_q;
  err_rec_t         cap_d;

  logic sbe_evt, dbe_evt, sbe_cap, capture;
  logic wr_ctrl, wr_mask, clr_sbe, clr_dbe;
  logic [CNT_W-1:0] sbe_cnt, dbe_cnt;
  logic [1:0] cause_q [NUM_CAUSE];
  logic [1:0] cause_any;
  logic [WORD_W-1:0] rd_mux;

  // register write decode
  assign wr_ctrl = reg_wen && (reg_addr == RA_CTRL);
  assign wr_mask = reg_wen && (reg_addr == RA_MASK);
  assign clr_sbe = reg_wen && (reg_addr == RA_SBECNT) && (reg_wdata == '0);
  assign clr_dbe = reg_wen && (reg_addr == RA_DBECNT) && (reg_wdata == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q  <= '0;
      prop_q <= 1'b0;
      mask_q <= '0;
    end else begin
      if (wr_ctrl) begin
        thr_q  <= reg_wdata[THR_LSB +: THR_W];
        prop_q <= reg_wdata[PROP_BIT];
      end
      if (wr_mask) begin
        mask_q <= reg_wdata[1:0];
      end
    end
  end

  ecc_evt_qual #(.THR_W(THR_W)) u_qual (
    .clk(clk), .rst(rst), .err_valid(err_valid), .err_dbe(err_dbe),
    .thr(thr_q), .thr_wr(wr_ctrl),
    .sbe_evt(sbe_evt), .dbe_evt(dbe_evt), .sbe_cap(sbe_cap), .capture(capture)
  );

  ecc_sat_counter #(.W(CNT_W)) u_sbe_cnt (
    .clk(clk), .rst(rst), .inc(sbe_evt), .clr(clr_sbe), .cnt(sbe_cnt)
  );

  ecc_sat_counter #(.W(CNT_W)) u_dbe_cnt (
    .clk(clk), .rst(rst), .inc(dbe_evt), .clr(clr_dbe), .cnt(dbe_cnt)
  );

  // capture record of the latest qualifying event
  always_comb begin
    cap_d.dbe  = err_dbe;
    cap_d.cs   = err_cs;
    cap_d.bank = err_bank;
    cap_d.row  = err_row;
    cap_d.col  = err_col;
    cap_d.data = err_data;
    cap_d.rx   = err_rx_ecc;
    cap_d.calc = err_calc_ecc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= '0;
    end else if (capture) begin
      cap_q <= cap_d;
    end
  end

  // sticky cause words
  generate
    for (genvar g = 0; g < NUM_CAUSE; g++) begin : g_cause
      ecc_cause_reg u_cause (
        .clk(clk), .rst(rst),
        .set({dbe_evt, sbe_cap}),
        .wen(reg_wen && (reg_addr == REG_AW'(RA_CAUSE0) + REG_AW'(g))),
        .wdata(reg_wdata[1:0]),
        .q(cause_q[g])
      );
    end
  endgenerate

  always_comb begin
    cause_any = '0;
    for (int i = 0; i < NUM_CAUSE; i++) begin
      cause_any = cause_any | cause_q[i];
    end
  end

  // read mux
  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      RA_CTRL: begin
        rd_mux[THR_LSB +: THR_W] = thr_q;
        rd_mux[PROP_BIT]         = prop_q;
      end
      RA_DHI:    rd_mux = cap_q.data[DATA_W-1:WORD_W];
      RA_DLO:    rd_mux = cap_q.data[WORD_W-1:0];
      RA_RXECC:  rd_mux[ECC_W-1:0] = cap_q.rx;
      RA_CALC: begin
        rd_mux[ECC_W-1:0]          = cap_q.calc;
        rd_mux[ROW_LSB +: ROW_W]   = cap_q.row;
      end
      RA_ADDR: begin
        rd_mux[0]                  = cap_q.dbe;
        rd_mux[CS_LSB +: CS_W]     = cap_q.cs;
        rd_mux[COL_LSB +: COL_W]   = cap_q.col;
        rd_mux[BANK_LSB +: BANK_W] = cap_q.bank;
      end
      RA_SBECNT: rd_mux = WORD_W'(sbe_cnt);
      RA_DBECNT: rd_mux = WORD_W'(dbe_cnt);
      RA_CAUSE0: rd_mux[1:0] = cause_q[0];
      RA_CAUSE1: rd_mux[1:0] = cause_q[NUM_CAUSE-1];
      RA_MASK:   rd_mux[1:0] = mask_q;
      RA_SYND:   rd_mux[ECC_W-1:0] = cap_q.rx ^ cap_q.calc;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
      ue_fwd    <= 1'b0;
    end else begin
      reg_rdata <= rd_mux;
      irq       <= |(cause_any & mask_q);
      ue_fwd    <= dbe_evt & prop_q;
    end
  end

  // R2: a double-bit strobe leaves its kind in the capture
  a_r2_dbe_captured: assert property (@(posedge clk) disable iff (rst)
    dbe_evt |=> cap_q.dbe);
  // R8: a zero mask keeps the interrupt low
  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (mask_q == 2'b00) |=> !irq);
  // R9: propagation disabled keeps the forward pulse low
  a_r9_no_fwd: assert property (@(posedge clk) disable iff (rst)
    !prop_q |=> !ue_fwd);
  // R9: forward pulse only follows a double-bit strobe
  a_r9_fwd_source: assert property (@(posedge clk) disable iff (rst)
    !dbe_evt |=> !ue_fwd);
endmodule

// File: tb/test_dram_ecc_capture.sv
module test_dram_ecc_capture;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        err_valid = 1'b0;
  logic        err_dbe = 1'b0;
  logic [1:0]  err_cs = '0;
  logic [2:0]  err_bank = '0;
  logic [15:0] err_row = '0;
  logic [14:0] err_col = '0;
  logic [63:0] err_data = '0;
  logic [7:0]  err_rx_ecc = '0;
  logic [7:0]  err_calc_ecc = '0;
  logic        reg_wen = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        ue_fwd;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  dram_ecc_capture #(.CNT_W(4), .THR_W(8), .NUM_CAUSE(2)) i_dram_ecc_capture (
    .clk(clk), .rst(rst), .err_valid(err_valid), .err_dbe(err_dbe),
    .err_cs(err_cs), .err_bank(err_bank), .err_row(err_row), .err_col(err_col),
    .err_data(err_data), .err_rx_ecc(err_rx_ecc), .err_calc_ecc(err_calc_ecc),
    .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .ue_fwd(ue_fwd)
  );

  // per-event attribute generators
  function automatic logic [31:0] f_hi(int k);  return 32'h1000_0000 + 32'(k) * 32'h0101_0103; endfunction
  function automatic logic [31:0] f_lo(int k);  return ~f_hi(k) ^ 32'(k); endfunction
  function automatic logic [15:0] f_row(int k); return 16'h0100 + 16'(k * 7); endfunction
  function automatic logic [14:0] f_col(int k); return 15'h0040 + 15'(k * 3); endfunction
  function automatic logic [2:0]  f_bank(int k); return 3'(k % 8); endfunction
  function automatic logic [1:0]  f_cs(int k);   return 2'(k % 4); endfunction
  function automatic logic [7:0]  f_rx(int k);   return 8'h30 + 8'(k); endfunction
  function automatic logic [7:0]  f_calc(int k); return 8'(k * 17) ^ 8'h5A; endfunction

  function automatic logic [31:0] x_addr(int k, bit dbe);
    if (k < 0) return 32'h0;
    return {6'b0, f_bank(k), f_col(k), 5'b0, f_cs(k), dbe};
  endfunction
  function automatic logic [31:0] x_calc(int k);
    if (k < 0) return 32'h0;
    return {8'h00, f_row(k), f_calc(k)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  // drive one strobe, optionally with a same-cycle register write; returns ue_fwd one cycle later
  task automatic evt(input int k, input bit dbe, input bit do_wr,
                     input logic [3:0] a, input logic [31:0] d, output logic ue);
    @(negedge clk);
    err_valid = 1'b1; err_dbe = dbe;
    err_cs = f_cs(k); err_bank = f_bank(k); err_row = f_row(k); err_col = f_col(k);
    err_data = {f_hi(k), f_lo(k)}; err_rx_ecc = f_rx(k); err_calc_ecc = f_calc(k);
    if (do_wr) begin
      reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    end
    @(negedge clk);
    ue = ue_fwd;
    err_valid = 1'b0; reg_wen = 1'b0;
  endtask

  task automatic chk_capture(input string req, input int k, input bit dbe);
    logic [31:0] v;
    rd(4'd5, v);  chk(req, v, x_addr(k, dbe));
    rd(4'd4, v);  chk(req, v, x_calc(k));
    rd(4'd1, v);  chk(req, v, (k < 0) ? 32'h0 : f_hi(k));
    rd(4'd2, v);  chk(req, v, (k < 0) ? 32'h0 : f_lo(k));
    rd(4'd3, v);  chk(req, v, (k < 0) ? 32'h0 : {24'h0, f_rx(k)});
    rd(4'd11, v); chk("R7", v, (k < 0) ? 32'h0 : {24'h0, f_rx(k) ^ f_calc(k)});
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic ue;
    int gk;
    int cap_k;
    bit cap_dbe;
    gk = 0;
    cap_k = -1;
    cap_dbe = 1'b0;

    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      chk("R1", v, 32'h0);
    end
    chk("R1", {31'h0, irq}, 32'h0);
    chk("R1", {31'h0, ue_fwd}, 32'h0);

    // R3/R10/R7 threshold sweep over single-bit events
    for (int thr = 0; thr <= 4; thr++) begin
      wr(4'd0, 32'(thr) << 16);
      wr(4'd6, 32'h0);
      wr(4'd8, 32'h0);
      wr(4'd9, 32'h0);
      for (int i = 0; i < 8; i++) begin
        evt(gk, 1'b0, 1'b0, 4'd0, 32'h0, ue);
        if (thr != 0 && ((i + 1) % thr) == 0) begin
          cap_k = gk; cap_dbe = 1'b0;
        end
        gk++;
      end
      chk_capture("R3", cap_k, cap_dbe);
      rd(4'd6, v); chk("R4", v, 32'd8);
      rd(4'd8, v); chk("R3", v, (thr != 0) ? 32'h1 : 32'h0);
      rd(4'd9, v); chk("R6", v, (thr != 0) ? 32'h1 : 32'h0);
    end

    // R2 double-bit capture with threshold zero
    wr(4'd0, 32'h0);
    wr(4'd8, 32'h0);
    wr(4'd9, 32'h0);
    evt(gk, 1'b1, 1'b0, 4'd0, 32'h0, ue);
    cap_k = gk; cap_dbe = 1'b1; gk++;
    chk_capture("R2", cap_k, cap_dbe);
    rd(4'd7, v); chk("R2", v, 32'd1);
    rd(4'd8, v); chk("R2", v, 32'h2);
    rd(4'd9, v); chk("R2", v, 32'h2);
    // single-bit at threshold zero: not captured, still counted
    wr(4'd6, 32'h0);
    evt(gk, 1'b0, 1'b0, 4'd0, 32'h0, ue); gk++;
    chk_capture("R3", cap_k, cap_dbe);
    rd(4'd6, v); chk("R4", v, 32'd1);
    // R10 overwrite by a newer double-bit event
    evt(gk, 1'b1, 1'b0, 4'd0, 32'h0, ue);
    cap_k = gk; cap_dbe = 1'b1; gk++;
    chk_capture("R10", cap_k, cap_dbe);

    // R4 saturation with 4-bit counters
    wr(4'd7, 32'h0);
    for (int n = 1; n <= 18; n++) begin
      evt(gk, 1'b1, 1'b0, 4'd0, 32'h0, ue); gk++;
      rd(4'd7, v);
      chk("R4", v, (n > 15) ? 32'd15 : 32'(n));
    end

    // R5 counter clear rules
    wr(4'd7, 32'h5);
    rd(4'd7, v); chk("R5", v, 32'd15);
    wr(4'd7, 32'h0);
    rd(4'd7, v); chk("R5", v, 32'd0);
    wr(4'd6, 32'h3);
    rd(4'd6, v); chk("R5", v, 32'd1);
    evt(gk, 1'b0, 1'b1, 4'd6, 32'h0, ue); gk++;
    rd(4'd6, v); chk("R5", v, 32'd1);

    // R6 cause write-zero-to-clear and set priority
    wr(4'd8, 32'h0);
    wr(4'd9, 32'h0);
    wr(4'd0, 32'h1 << 16);
    evt(gk, 1'b0, 1'b0, 4'd0, 32'h0, ue); gk++;
    rd(4'd8, v); chk("R6", v, 32'h1);
    evt(gk, 1'b1, 1'b0, 4'd0, 32'h0, ue); gk++;
    rd(4'd8, v); chk("R6", v, 32'h3);
    wr(4'd8, 32'h1);
    rd(4'd8, v); chk("R6", v, 32'h1);
    rd(4'd9, v); chk("R6", v, 32'h3);
    evt(gk, 1'b0, 1'b1, 4'd8, 32'h0, ue); gk++;
    rd(4'd8, v); chk("R6", v, 32'h1);

    // R8 interrupt masking (cause0=01, cause1=11)
    wr(4'd10, 32'h2);
    @(negedge clk);
    chk("R8", {31'h0, irq}, 32'h1);
    wr(4'd9, 32'h1);
    @(negedge clk);
    chk("R8", {31'h0, irq}, 32'h0);
    wr(4'd10, 32'h1);
    @(negedge clk);
    chk("R8", {31'h0, irq}, 32'h1);
    wr(4'd10, 32'h0);
    @(negedge clk);
    chk("R8", {31'h0, irq}, 32'h0);

    // R9 forwarding of uncorrectable errors
    wr(4'd0, 32'h1 << 16);
    evt(gk, 1'b1, 1'b0, 4'd0, 32'h0, ue); gk++;
    chk("R9", {31'h0, ue}, 32'h0);
    wr(4'd0, (32'h1 << 16) | (32'h1 << 9));
    rd(4'd0, v); chk("R9", v, 32'h0001_0200);
    evt(gk, 1'b1, 1'b0, 4'd0, 32'h0, ue); gk++;
    chk("R9", {31'h0, ue}, 32'h1);
    @(negedge clk);
    chk("R9", {31'h0, ue_fwd}, 32'h0);
    evt(gk, 1'b0, 1'b0, 4'd0, 32'h0, ue); gk++;
    chk("R9", {31'h0, ue}, 32'h0);

    // R11 unmapped addresses
    for (int a = 12; a < 16; a++) begin
      rd(4'(a), v);
      chk("R11", v, 32'h0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule